// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block computes and verifies even parity for a 64-bit multiplexed address/data bus and its 8-bit command/byte-enable bus. Each 32-bit half of the data bus has its own lane: lane 0 covers data bits 31..0 with command bits 3..0, and lane 1 covers data bits 63..32 with command bits 7..4. Each lane's parity bit is chosen so that the count of ones across its data bits, its command bits and the parity bit is even.

When the block's own agent drives a phase, the lane parity bits and their output enables appear on the next clock. When another agent drives the phase, the block compares the parity received on the next clock with its own result. It then reports a failure one clock after that. A failing data phase gives a data-parity error, and a failing address phase gives a system-error pull-down. Each report is gated by its own enable bit in the command register. Lane 1 takes part only in 64-bit transfers.

Top module: `bus_parity_unit`

## Requirements
- R1: When `drive_i` is high in cycle T, `gen_oe_o[0]` is high in cycle T+1. In that cycle `gen_par_o[0]` equals the XOR of `ad_i[31:0]` and `cbe_i[3:0]` from cycle T, which makes the ones count of the lane even.
- R2: When `drive_i` and `wide_i` are both high in cycle T, `gen_oe_o[1]` is high in cycle T+1. In that cycle `gen_par_o[1]` equals the XOR of `ad_i[63:32]` and `cbe_i[7:4]` from cycle T. If `wide_i` is low, `gen_oe_o[1]` is low.
- R3: When `drive_i` is low in cycle T, both bits of `gen_oe_o` are low in cycle T+1.
- R4: A cycle is an address phase when `frame_n_i` is low in it and was high in the cycle before. The cycle before the first cycle after reset counts as high. While `frame_n_i` stays low, later cycles are not address phases.
- R5: A cycle that is not an address phase is a data phase when both `irdy_n_i` and `trdy_n_i` are low in it. Other cycles are never checked.
- R6: A received data phase in cycle T fails when `rx_par_i` in cycle T+1 differs from the computed parity of a lane that is checked. If `cmd_reg_i[6]` is high in cycle T+1, `perr_n_o` is low for exactly cycle T+2.
- R7: When `cmd_reg_i[6]` is low in cycle T+1, a failing data phase leaves `perr_n_o` high.
- R8: Lane 1 is checked only when `wide_i` was high in the phase cycle. Otherwise a mismatch on `rx_par_i[1]` has no effect.
- R9: A received address phase in cycle T fails by the same rule as R6. If `cmd_reg_i[8]` is high in cycle T+1, `serr_pull_o` is high for exactly cycle T+2. An address failure never lowers `perr_n_o`, and a data failure never raises `serr_pull_o`.
- R10: A phase with `drive_i` high is never checked. Received parity after such a phase raises no error.
- R11: While `rst_n` is low, `gen_oe_o` is zero, `perr_n_o` is high and `serr_pull_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ad_i | input | 64 | Address/data bus value |
| cbe_i | input | 8 | Command/byte-enable bus value |
| frame_n_i | input | 1 | Transaction frame, active low |
| irdy_n_i | input | 1 | Initiator ready, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| wide_i | input | 1 | Current transfer is 64 bits wide |
| drive_i | input | 1 | This agent drives the current phase |
| cmd_reg_i | input | 16 | Command register; bit 6 enables data-parity reports, bit 8 enables system-error reports |
| rx_par_i | input | 2 | Received parity, bit 0 for lane 0 and bit 1 for lane 1 |
| gen_par_o | output | 2 | Generated parity, one bit per lane |
| gen_oe_o | output | 2 | Output enable for each generated parity bit |
| perr_n_o | output | 1 | Data-parity error, active low |
| serr_pull_o | output | 1 | Pull-down request for the open-drain system-error line |

## Verification
The bench targets timing slips. A design that compared received parity against the wrong phase, or reported one cycle early or late, would mismatch on almost every injected single-bit error. Frame held low across many cycles checks R4: a detector that flags every low frame cycle would raise system errors where data errors belong. Lane-1 errors injected on 32-bit transfers catch a checker that ignores the width flag. Errors injected while the enable bits are clear, or while this agent drives, catch gating taken from the wrong cycle or missing altogether.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

    typedef enum logic [1:0] {
        PH_NONE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

endpackage

// File: rtl/bpu_lane_parity.sv
module bpu_lane_parity #(
    parameter int DW = 32,
    parameter int CW = 4
) (
    input  logic [DW-1:0] data_i,
    input  logic [CW-1:0] cmd_i,
    output logic          odd_o
);
    // Parity bit that evens out the lane's ones count.
    always_comb begin
        odd_o = ^{data_i, cmd_i};
    end
endmodule

// File: rtl/bpu_phase_detect.sv
module bpu_phase_detect
    import bpu_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   frame_n_i,
    input  logic   irdy_n_i,
    input  logic   trdy_n_i,
    output phase_e phase_o
);
    typedef struct packed {
        logic frame_prev;
    } det_st_t;

    det_st_t st_d, st_q;

    always_comb begin
        st_d            = st_q;
        st_d.frame_prev = frame_n_i;
        if (st_q.frame_prev && !frame_n_i) begin
            phase_o = PH_ADDR;
        end else if (!irdy_n_i && !trdy_n_i) begin
            phase_o = PH_DATA;
        end else begin
            phase_o = PH_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.frame_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit
    import bpu_pkg::*;
#(
    parameter int LANE_W      = 32,
    parameter int CMD_LANE_W  = 4,
    parameter int LANES       = 2,
    parameter int CREG_W      = 16,
    parameter int PERR_EN_BIT = 6,
    parameter int SERR_EN_BIT = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LANE_W*LANES-1:0]       ad_i,
    input  logic [CMD_LANE_W*LANES-1:0]   cbe_i,
    input  logic                          frame_n_i,
    input  logic                          irdy_n_i,
    input  logic                          trdy_n_i,
    input  logic                          wide_i,
    input  logic                          drive_i,
    input  logic [CREG_W-1:0]             cmd_reg_i,
    input  logic [LANES-1:0]              rx_par_i,
    output logic [LANES-1:0]              gen_par_o,
    output logic [LANES-1:0]              gen_oe_o,
    output logic                          perr_n_o,
    output logic                          serr_pull_o
);
    localparam int DATA_W = LANE_W * LANES;
    localparam int CMD_W  = CMD_LANE_W * LANES;

    typedef struct packed {
        logic [LANES-1:0] par;       // parity of the phase just captured
        logic [LANES-1:0] oe;        // lanes driven out
        logic [LANES-1:0] chk_lane;  // lanes to compare next cycle
        logic             chk_addr;  // received address phase pending compare
        logic             chk_data;  // received data phase pending compare
        logic             perr_n;
        logic             serr;
    } unit_st_t;

    unit_st_t st_d, st_q;
    phase_e   phase;
    logic [LANES-1:0] lane_odd;
    logic [LANES-1:0] lane_active;
    logic             mismatch;

    bpu_phase_detect u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n_i (frame_n_i),
        .irdy_n_i  (irdy_n_i),
        .trdy_n_i  (trdy_n_i),
        .phase_o   (phase)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        bpu_lane_parity #(
            .DW (LANE_W),
            .CW (CMD_LANE_W)
        ) u_par (
            .data_i (ad_i[g*LANE_W +: LANE_W]),
            .cmd_i  (cbe_i[g*CMD_LANE_W +: CMD_LANE_W]),
            .odd_o  (lane_odd[g])
        );
        // Lane 0 always takes part; upper lanes only on wide transfers.
        if (g == 0) begin : g_base
            assign lane_active[g] = 1'b1;
        end else begin : g_upper
            assign lane_active[g] = wide_i;
        end
    end

    always_comb begin
        st_d          = st_q;
        mismatch      = |((rx_par_i ^ st_q.par) & st_q.chk_lane);
        st_d.par      = lane_odd;
        st_d.oe       = drive_i ? lane_active : '0;
        st_d.chk_lane = drive_i ? '0 : lane_active;
        st_d.chk_addr = !drive_i && (phase == PH_ADDR);
        st_d.chk_data = !drive_i && (phase == PH_DATA);
        st_d.perr_n   = !(st_q.chk_data && mismatch && cmd_reg_i[PERR_EN_BIT]);
        st_d.serr     = st_q.chk_addr && mismatch && cmd_reg_i[SERR_EN_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.perr_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign gen_par_o   = st_q.par;
    assign gen_oe_o    = st_q.oe;
    assign perr_n_o    = st_q.perr_n;
    assign serr_pull_o = st_q.serr;

    logic unused_w;
    assign unused_w = ^{DATA_W[0], CMD_W[0]};
endmodule

// File: rtl/bus_parity_unit_chk.sv
module bus_parity_unit_chk #(
    parameter int LANES       = 2,
    parameter int CREG_W      = 16,
    parameter int PERR_EN_BIT = 6,
    parameter int SERR_EN_BIT = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              drive_i,
    input logic [CREG_W-1:0] cmd_reg_i,
    input logic [LANES-1:0]  gen_oe_o,
    input logic              perr_n_o,
    input logic              serr_pull_o
);
    // R3
    oe_needs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_oe_o[0] == $past(drive_i)));
    // R2
    upper_oe_implies_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_oe_o[LANES-1] |-> gen_oe_o[0]);
    // R7
    perr_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n_o |-> $past(cmd_reg_i[PERR_EN_BIT]));
    // R9
    serr_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serr_pull_o |-> $past(cmd_reg_i[SERR_EN_BIT]));
    // R9
    error_kinds_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(serr_pull_o && !perr_n_o));
    // R10
    no_error_on_own_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!perr_n_o || serr_pull_o) |-> !$past(drive_i, 2));
endmodule

bind bus_parity_unit bus_parity_unit_chk #(
    .LANES       (LANES),
    .CREG_W      (CREG_W),
    .PERR_EN_BIT (PERR_EN_BIT),
    .SERR_EN_BIT (SERR_EN_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .drive_i     (drive_i),
    .cmd_reg_i   (cmd_reg_i),
    .gen_oe_o    (gen_oe_o),
    .perr_n_o    (perr_n_o),
    .serr_pull_o (serr_pull_o)
);

// File: tb/bus_parity_unit_bench.sv
module bus_parity_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    typedef struct {
        logic [63:0] ad;
        logic [7:0]  cbe;
        logic        frame_n, irdy_n, trdy_n, wide, drive;
        logic [15:0] creg;
        logic [1:0]  inj;
        logic [1:0]  rx;
    } stim_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] ad = '0;
    logic [7:0]  cbe = '0;
    logic        frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1;
    logic        wide = 1'b0, drive = 1'b0;
    logic [15:0] creg = '0;
    logic [1:0]  rx = '0;
    logic [1:0]  gen_par, gen_oe;
    logic        perr_n, serr_pull;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    stim_t cur, prv;
    logic  fprev_cur, fprev_prv;

    bus_parity_unit u_bus_parity_unit (
        .clk (clk), .rst_n (rst_n), .ad_i (ad), .cbe_i (cbe),
        .frame_n_i (frame_n), .irdy_n_i (irdy_n), .trdy_n_i (trdy_n),
        .wide_i (wide), .drive_i (drive), .cmd_reg_i (creg), .rx_par_i (rx),
        .gen_par_o (gen_par), .gen_oe_o (gen_oe),
        .perr_n_o (perr_n), .serr_pull_o (serr_pull)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic lane_par(stim_t s, int lane);
        return lane == 0 ? ^{s.ad[31:0], s.cbe[3:0]} : ^{s.ad[63:32], s.cbe[7:4]};
    endfunction

    // 0 none, 1 address, 2 data
    function automatic int phase_of(logic fprev, stim_t s);
        if (fprev && !s.frame_n) return 1;
        if (!s.irdy_n && !s.trdy_n) return 2;
        return 0;
    endfunction

    function automatic stim_t idle();
        stim_t s;
        s.ad = '0; s.cbe = '0; s.frame_n = 1'b1; s.irdy_n = 1'b1; s.trdy_n = 1'b1;
        s.wide = 1'b0; s.drive = 1'b0; s.creg = '0; s.inj = '0; s.rx = '0;
        return s;
    endfunction

    function automatic stim_t rnd();
        stim_t s;
        s.ad      = {$urandom, $urandom};
        s.cbe     = 8'($urandom);
        s.frame_n = ($urandom % 3) == 0;
        s.irdy_n  = ($urandom % 3) == 0;
        s.trdy_n  = ($urandom % 3) == 0;
        s.wide    = $urandom % 2;
        s.drive   = ($urandom % 5) == 0;
        s.creg    = 16'($urandom);
        s.creg[6] = ($urandom % 4) != 0;
        s.creg[8] = ($urandom % 4) != 0;
        s.inj[0]  = ($urandom % 4) == 0;
        s.inj[1]  = ($urandom % 4) == 0;
        s.rx      = '0;
        return s;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(stim_t s);
        int  ph;
        logic mis_lo, mis_hi, m, exp_perr, exp_serr;
        string tag;
        @(negedge clk);
        // Generation results for the phase captured last edge (R1, R2, R3)
        check(cur.drive ? "R1" : "R3", 32'(gen_oe[0]), 32'(cur.drive));
        check(cur.drive ? "R2" : "R3", 32'(gen_oe[1]), 32'(cur.drive && cur.wide));
        if (cur.drive) check("R1", 32'(gen_par[0]), 32'(lane_par(cur, 0)));
        if (cur.drive && cur.wide) check("R2", 32'(gen_par[1]), 32'(lane_par(cur, 1)));
        // Error results for the phase one earlier
        ph       = phase_of(fprev_prv, prv);
        mis_lo   = cur.rx[0] != lane_par(prv, 0);
        mis_hi   = prv.wide && (cur.rx[1] != lane_par(prv, 1));
        m        = !prv.drive && (mis_lo || mis_hi);
        exp_perr = (ph == 2) && m && cur.creg[6];
        exp_serr = (ph == 1) && m && cur.creg[8];
        if (prv.drive) tag = "R10";
        else if (!prv.wide && prv.inj[1] && !prv.inj[0]) tag = "R8";
        else if (ph == 2) tag = cur.creg[6] ? "R6" : "R7";
        else if (ph == 1) tag = "R4";
        else tag = "R5";
        check(tag, 32'(!perr_n), 32'(exp_perr));
        check(ph == 1 ? "R9" : tag, 32'(serr_pull), 32'(exp_serr));
        // Advance the model and drive the next cycle
        s.rx      = {lane_par(cur, 1), lane_par(cur, 0)} ^ s.inj;
        fprev_prv = fprev_cur;
        fprev_cur = cur.frame_n;
        prv       = cur;
        cur       = s;
        ad = s.ad; cbe = s.cbe; frame_n = s.frame_n; irdy_n = s.irdy_n;
        trdy_n = s.trdy_n; wide = s.wide; drive = s.drive; creg = s.creg; rx = s.rx;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        stim_t s;
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);
        cur = idle(); prv = idle(); fprev_cur = 1'b1; fprev_prv = 1'b1;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11", 32'(gen_oe), 32'd0);
        check("R11", 32'(perr_n), 32'd1);
        check("R11", 32'(serr_pull), 32'd0);
        rst_n = 1'b1;

        // Directed: received address phase with lane-0 error, system error enabled (R4, R9)
        s = idle(); s.frame_n = 0; s.ad = 64'h0123_4567_89ab_cdef; s.cbe = 8'h6a;
        step(s);
        s = idle(); s.frame_n = 0; s.creg[8] = 1; s.inj = 2'b01; step(s);
        // Frame held low; wide data phase with lane-1 error, perr enabled (R6)
        s = idle(); s.frame_n = 0; s.irdy_n = 0; s.trdy_n = 0; s.wide = 1;
        s.ad = 64'hffff_0000_1234_5678; step(s);
        s = idle(); s.frame_n = 0; s.creg[6] = 1; s.inj = 2'b10; step(s);
        // Narrow data phase with only lane-1 error: ignored (R8)
        s = idle(); s.frame_n = 0; s.irdy_n = 0; s.trdy_n = 0; s.ad = 64'h8000_0001_0000_0003;
        step(s);
        s = idle(); s.frame_n = 0; s.creg = 16'h0140; s.inj = 2'b10; step(s);
        // Data error with perr disabled (R7)
        s = idle(); s.frame_n = 0; s.irdy_n = 0; s.trdy_n = 0; step(s);
        s = idle(); s.frame_n = 0; s.creg = 16'h0100; s.inj = 2'b01; step(s);
        // Own driven wide phase with error afterwards (R1, R2, R10)
        s = idle(); s.frame_n = 0; s.irdy_n = 0; s.trdy_n = 0; s.drive = 1; s.wide = 1;
        s.ad = 64'hdead_beef_cafe_f00d; s.cbe = 8'h3c; step(s);
        s = idle(); s.creg = 16'h0140; s.inj = 2'b11; step(s);
        // Back-to-back data phases, both failing (R5, R6)
        s = idle(); s.frame_n = 0; step(s);
        s = idle(); s.frame_n = 0; s.irdy_n = 0; s.trdy_n = 0; s.creg = 16'h0140; step(s);
        s = idle(); s.frame_n = 0; s.irdy_n = 0; s.trdy_n = 0; s.creg = 16'h0140; s.inj = 2'b01;
        s.ad = 64'h5; step(s);
        s = idle(); s.creg = 16'h0140; s.inj = 2'b01; step(s);
        s = idle(); step(s);

        for (int i = 0; i < N_RANDOM; i++) begin
            step(rnd());
        end
        step(idle());
        step(idle());
        finish_run();
    end
endmodule